// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Clock

This core keeps wall-clock time as a 32-bit count of seconds. It runs directly on a slow oscillator clock, and every oscillator cycle counts as one tick. A programmable prescaler divides the ticks into seconds. A 4-bit fractional field can lengthen chosen seconds by one extra tick. Spread over a 16-second cycle, this trims the average second length in sixteenths of a tick.

Software uses a small word-addressed register bus. Through it, software loads a new time, programs the trim, arms a 32-bit alarm, and services two interrupt lines: one for every second and one for the alarm. A new time is held pending and only replaces the running count at the next second boundary. The newly written value can be read back at once from a separate register. Two control bits, a battery-switch enable and an oscillator enable, are only stored and read back.

Top module: `cal_rtc`

## Requirements
- R1: After reset:
  - the calibration readback (offset 0x0C) returns 0x00007FFF;
  - current time (0x10), set-time readback (0x04), alarm (0x18), status (0x20), mask (0x24) and control (0x40) all read 0;
  - both interrupt outputs are low.
- R2: With reload value R in calibration bits 15:0, the tick counter runs 0..R and one second lasts R+1 clock cycles. Offset 0x14 returns the live tick count.
- R3: Fractional compensation:
  - When calibration bit 20 is 1, the 4-bit count F in bits 19:16 stretches exactly F of every 16 consecutive seconds by one tick.
  - When bit 20 is 0, F has no effect on the second length.
- R4: A write to offset 0x08 stores only calibration bits 20:0 and restarts the tick counter and the fractional phase. The readback at 0x0C returns the stored 21 bits.
- R5: Setting the time:
  - A write to offset 0x00 is returned by 0x04 immediately.
  - Current time keeps its old value until the next second boundary.
  - At that boundary, current time becomes the written value, and it then counts on from there.
- R6: At every second boundary, the seconds counter advances by one unless a set-time value is pending. Status bit 0 is set at every boundary.
- R7: Status bit 1 is set at the boundary where the seconds counter takes a value equal to the alarm register (offset 0x18, read/write).
- R8: Writing to status (0x20) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: Interrupt enables:
  - Writing 1 to a bit at 0x28 enables that interrupt.
  - Writing 1 to a bit at 0x2C disables it.
  - Zero bits have no effect.
  - 0x24 reads the enables (bit 0 seconds, bit 1 alarm).
- R10: Each interrupt output is the registered AND of its status bit and its enable. Status bits set even while masked.
- R11: Control offset 0x40 stores bit 31 and bit 24 only. All other bits read 0.
- R12: Reads:
  - Read data appears the cycle after the read strobe and reflects state from before that edge.
  - Write-only and unmapped offsets read 0.
  - Read data holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench builds the core with its default parameters: 16-bit reload, 4-bit fraction, 32-bit seconds and 8-bit offsets. At run time it then programs reloads of 3 to 20 ticks. This brings whole 16-second fractional cycles, set-time boundaries and alarm matches within a few hundred cycles. It also keeps the 0x7FFF reset reload observable. The vector table sweeps the trim cases: fraction enabled and disabled, fraction 0, 1, 8 and 15, and several reloads. It checks both the 16-second total and that each single second is one of the two legal lengths.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  // Register offsets (software decodes these)
  localparam int OFS_SET_WR  = 'h00;
  localparam int OFS_SET_RD  = 'h04;
  localparam int OFS_CAL_WR  = 'h08;
  localparam int OFS_CAL_RD  = 'h0C;
  localparam int OFS_NOW     = 'h10;
  localparam int OFS_TICK    = 'h14;
  localparam int OFS_ALARM   = 'h18;
  localparam int OFS_STATUS  = 'h20;
  localparam int OFS_MASK    = 'h24;
  localparam int OFS_ENABLE  = 'h28;
  localparam int OFS_DISABLE = 'h2C;
  localparam int OFS_CTRL    = 'h40;

  // Interrupt source positions
  localparam int SRC_SEC   = 0;
  localparam int SRC_ALARM = 1;
  localparam int NUM_SRC   = 2;

  // Control bit positions
  localparam int CTL_BATT_BIT = 31;
  localparam int CTL_OSC_BIT  = 24;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [TICK_W-1:0] reload,
  input  logic              frac_en,
  input  logic [FRAC_W-1:0] frac,
  output logic [TICK_W:0]   tick_cnt,
  output logic              wrap
);
  localparam int CNT_W = TICK_W + 1;
  localparam int ACC_W = FRAC_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic              stretch;
  logic [CNT_W-1:0]  limit;
  logic [ACC_W-1:0]  acc_sum;

  always_comb begin
    limit   = {1'b0, reload} + CNT_W'(stretch);
    wrap    = (cnt == limit) && !restart;
    acc_sum = {1'b0, acc} + {1'b0, (frac_en ? frac : {FRAC_W{1'b0}})};
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt     <= '0;
      acc     <= '0;
      stretch <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      stretch <= acc_sum[FRAC_W];
      acc     <= acc_sum[FRAC_W-1:0];
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick_cnt = cnt;

  // R2: the tick count never exceeds reload plus one stretch tick
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt <= ({1'b0, reload} + CNT_W'(1)));

  // R3: with compensation off, no second is stretched
  a_r3_no_stretch_when_off: assert property (@(posedge clk) disable iff (rst)
    (!frac_en && wrap) |=> !stretch);
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic             set_wr,
  input  logic [SEC_W-1:0] set_data,
  input  logic [SEC_W-1:0] alarm_val,
  output logic [SEC_W-1:0] secs,
  output logic [SEC_W-1:0] set_val,
  output logic             sec_evt,
  output logic             alarm_evt
);
  logic             pend;
  logic [SEC_W-1:0] next_secs;

  always_comb begin
    next_secs = pend ? set_val : secs + 1'b1;
    sec_evt   = wrap;
    alarm_evt = wrap && (next_secs == alarm_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      secs    <= '0;
      set_val <= '0;
      pend    <= 1'b0;
    end else begin
      if (set_wr) set_val <= set_data;
      if (wrap)   secs    <= next_secs;
      if (set_wr)     pend <= 1'b1;
      else if (wrap)  pend <= 1'b0;
    end
  end

  // R6: a plain boundary advances by exactly one
  a_r6_advance_one: assert property (@(posedge clk) disable iff (rst)
    (wrap && !pend) |=> (secs == $past(secs) + SEC_W'(1)));

  // R5: a pending value is loaded at the boundary
  a_r5_pending_loads: assert property (@(posedge clk) disable iff (rst)
    (wrap && pend) |=> (secs == $past(set_val)));

  // R5: the running count holds between boundaries
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(secs));
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_wr,
  input  logic            en_wr,
  input  logic            dis_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] enable,
  output logic [NSRC-1:0] irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        status[i] <= 1'b0;
        enable[i] <= 1'b0;
        irq[i]    <= 1'b0;
      end else begin
        if (evt[i])                      status[i] <= 1'b1;
        else if (clr_wr && wbits[i])     status[i] <= 1'b0;
        if (en_wr && wbits[i])           enable[i] <= 1'b1;
        else if (dis_wr && wbits[i])     enable[i] <= 1'b0;
        irq[i] <= status[i] & enable[i];
      end
    end

    // R8: an event sets its bit even against a same-cycle clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> status[i]);

    // R10: a disabled source keeps its line low next cycle
    a_r10_masked_low: assert property (@(posedge clk) disable iff (rst)
      !enable[i] |=> !irq[i]);
  end
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc #(
  parameter int                 TICK_W     = 16,
  parameter int                 FRAC_W     = 4,
  parameter int                 SEC_W      = 32,
  parameter int                 ADDR_W     = 8,
  parameter int                 DATA_W     = 32,
  parameter logic [TICK_W-1:0]  RST_RELOAD = 16'h7FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  import cal_rtc_pkg::*;

  localparam int FRAC_LSB = TICK_W;
  localparam int FEN_BIT  = TICK_W + FRAC_W;
  localparam int CAL_W    = FEN_BIT + 1;

  localparam logic [ADDR_W-1:0] A_SET_WR  = ADDR_W'(OFS_SET_WR);
  localparam logic [ADDR_W-1:0] A_SET_RD  = ADDR_W'(OFS_SET_RD);
  localparam logic [ADDR_W-1:0] A_CAL_WR  = ADDR_W'(OFS_CAL_WR);
  localparam logic [ADDR_W-1:0] A_CAL_RD  = ADDR_W'(OFS_CAL_RD);
  localparam logic [ADDR_W-1:0] A_NOW     = ADDR_W'(OFS_NOW);
  localparam logic [ADDR_W-1:0] A_TICK    = ADDR_W'(OFS_TICK);
  localparam logic [ADDR_W-1:0] A_ALARM   = ADDR_W'(OFS_ALARM);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_ENABLE  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DISABLE = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);

  // Register state
  logic [TICK_W-1:0] cal_reload;
  logic [FRAC_W-1:0] cal_frac;
  logic              cal_fen;
  logic [SEC_W-1:0]  alarm_q;
  logic              ctl_batt;
  logic              ctl_osc;

  // Write decode
  logic w_set, w_cal, w_alarm, w_clr, w_en, w_dis, w_ctl;
  always_comb begin
    w_set   = bus_wr && (bus_addr == A_SET_WR);
    w_cal   = bus_wr && (bus_addr == A_CAL_WR);
    w_alarm = bus_wr && (bus_addr == A_ALARM);
    w_clr   = bus_wr && (bus_addr == A_STATUS);
    w_en    = bus_wr && (bus_addr == A_ENABLE);
    w_dis   = bus_wr && (bus_addr == A_DISABLE);
    w_ctl   = bus_wr && (bus_addr == A_CTRL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_reload <= RST_RELOAD;
      cal_frac   <= '0;
      cal_fen    <= 1'b0;
      alarm_q    <= '0;
      ctl_batt   <= 1'b0;
      ctl_osc    <= 1'b0;
    end else begin
      if (w_cal) begin
        cal_reload <= bus_wdata[TICK_W-1:0];
        cal_frac   <= bus_wdata[FRAC_LSB +: FRAC_W];
        cal_fen    <= bus_wdata[FEN_BIT];
      end
      if (w_alarm) alarm_q <= bus_wdata[SEC_W-1:0];
      if (w_ctl) begin
        ctl_batt <= bus_wdata[CTL_BATT_BIT];
        ctl_osc  <= bus_wdata[CTL_OSC_BIT];
      end
    end
  end

  // Datapath
  logic [TICK_W:0]      tick_cnt;
  logic                 wrap;
  logic [SEC_W-1:0]     secs;
  logic [SEC_W-1:0]     set_val;
  logic                 sec_evt;
  logic                 alarm_evt;
  logic [NUM_SRC-1:0]   evt;
  logic [NUM_SRC-1:0]   status;
  logic [NUM_SRC-1:0]   enable;
  logic [NUM_SRC-1:0]   irq;

  rtc_prescaler #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) u_presc (
    .clk(clk), .rst(rst), .restart(w_cal),
    .reload(cal_reload), .frac_en(cal_fen), .frac(cal_frac),
    .tick_cnt(tick_cnt), .wrap(wrap)
  );

  rtc_seconds #(.SEC_W(SEC_W)) u_secs (
    .clk(clk), .rst(rst), .wrap(wrap),
    .set_wr(w_set), .set_data(bus_wdata[SEC_W-1:0]), .alarm_val(alarm_q),
    .secs(secs), .set_val(set_val), .sec_evt(sec_evt), .alarm_evt(alarm_evt)
  );

  always_comb begin
    evt            = '0;
    evt[SRC_SEC]   = sec_evt;
    evt[SRC_ALARM] = alarm_evt;
  end

  rtc_irq #(.NSRC(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .evt(evt),
    .clr_wr(w_clr), .en_wr(w_en), .dis_wr(w_dis),
    .wbits(bus_wdata[NUM_SRC-1:0]),
    .status(status), .enable(enable), .irq(irq)
  );

  assign irq_sec   = irq[SRC_SEC];
  assign irq_alarm = irq[SRC_ALARM];

  // Read mux, registered
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_SET_RD: rd_mux = DATA_W'(set_val);
      A_CAL_RD: rd_mux = DATA_W'({cal_fen, cal_frac, cal_reload});
      A_NOW:    rd_mux = DATA_W'(secs);
      A_TICK:   rd_mux = DATA_W'(tick_cnt);
      A_ALARM:  rd_mux = DATA_W'(alarm_q);
      A_STATUS: rd_mux = DATA_W'(status);
      A_MASK:   rd_mux = DATA_W'(enable);
      A_CTRL: begin
        rd_mux[CTL_BATT_BIT] = ctl_batt;
        rd_mux[CTL_OSC_BIT]  = ctl_osc;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R12: read data holds when no read is issued
  a_r12_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R4: a calibration write restarts the tick counter
  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    w_cal |=> (tick_cnt == '0));

  // R7: the alarm status bit rises only at a second boundary
  a_r7_alarm_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(status[SRC_ALARM]) |-> $past(wrap));
endmodule

// File: tb/cal_rtc_tb.sv
module cal_rtc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_sec;
  logic        irq_alarm;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cal_rtc u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  // Trim vectors: calibration word and expected length of 16 seconds
  localparam int NV = 6;
  localparam logic [31:0] CAL_VEC [NV] = '{
    32'h0000_0003, 32'h0018_0003, 32'h0008_0003,
    32'h001F_0005, 32'h0011_0004, 32'h0010_0003 };
  localparam int EXP_SUM [NV] = '{64, 72, 64, 111, 81, 64};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Tasks assume they start at a falling edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_addr = 8'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 8'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_sec_high();
    while (!irq_sec) @(negedge clk);
  endtask

  task automatic wait_sec_low();
    while (irq_sec) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] old0;
    int t_prev;
    int sum;
    int bad_len;
    int guard;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_sec", 32'(irq_sec), 0);
    chk("R1 irq_alarm", 32'(irq_alarm), 0);
    rd('h0C, d); chk("R1 calib", d, 32'h0000_7FFF);
    rd('h10, d); chk("R1 now", d, 0);
    rd('h04, d); chk("R1 setrd", d, 0);
    rd('h18, d); chk("R1 alarm", d, 0);
    rd('h20, d); chk("R1 status", d, 0);
    rd('h24, d); chk("R1 mask", d, 0);
    rd('h40, d); chk("R1 ctrl", d, 0);

    // R11 control storage
    wr('h40, 32'hFFFF_FFFF); rd('h40, d); chk("R11 ctrl all ones", d, 32'h8100_0000);
    wr('h40, 32'h0100_0000); rd('h40, d); chk("R11 ctrl osc only", d, 32'h0100_0000);

    // R4 only bits 20:0 stored; R12 write-only offset reads zero
    wr('h08, 32'hFFFF_FFFF); rd('h0C, d); chk("R4 calib width", d, 32'h001F_FFFF);
    rd('h08, d); chk("R12 write-only reads 0", d, 0);
    rd('h30, d); chk("R12 unmapped reads 0", d, 0);

    // R2 live tick and R4 restart
    wr('h08, 32'd20); rd('h14, d); chk("R2 tick after restart", d, 0);
    wr('h08, 32'd20);
    repeat (7) @(negedge clk);
    rd('h14, d); chk("R2 tick after 7 cycles", d, 7);

    // R9 enable, zero write no effect
    wr('h28, 32'h1); rd('h24, d); chk("R9 enable sec", d, 1);
    wr('h28, 32'h0); rd('h24, d); chk("R9 zero enable no effect", d, 1);

    // R2/R3 table of trim vectors
    for (int v = 0; v < NV; v++) begin
      int r;
      int fmax;
      r = int'(CAL_VEC[v][15:0]);
      fmax = (CAL_VEC[v][20] && CAL_VEC[v][19:16] != 0) ? r + 2 : r + 1;
      wr('h08, CAL_VEC[v]);
      wr('h20, 32'h3);
      wait_sec_low();
      wait_sec_high();
      t_prev = cyc;
      wr('h20, 32'h1);
      wait_sec_low();
      sum = 0; bad_len = 0;
      for (int s = 0; s < 16; s++) begin
        int len;
        wait_sec_high();
        len = cyc - t_prev;
        t_prev = cyc;
        sum += len;
        if (len < r + 1 || len > fmax) bad_len++;
        wr('h20, 32'h1);
        wait_sec_low();
      end
      chk($sformatf("R3 16-second length vec%0d", v), 32'(sum), 32'(EXP_SUM[v]));
      chk($sformatf("R2 per-second length vec%0d", v), 32'(bad_len), 0);
    end

    // R5 set-time behaviour
    wr('h2C, 32'h1); rd('h24, d); chk("R9 disable sec", d, 0);
    wr('h08, 32'd3);
    rd('h10, old0);
    wr('h00, 32'd100);
    rd('h04, d); chk("R5 set readback immediate", d, 100);
    rd('h10, d); chk("R5 now unchanged before boundary", d, old0);
    rd('h10, d); chk("R5 now loaded at boundary", d, 100);
    repeat (3) @(negedge clk);
    rd('h10, d); chk("R6 counts on", d, 101);

    // R7 alarm, R10 masking
    wr('h18, 32'd103);
    rd('h18, d); chk("R7 alarm readback", d, 103);
    wr('h20, 32'h3);
    wr('h28, 32'h2);
    guard = 0;
    while (!irq_alarm && guard < 60) begin @(negedge clk); guard++; end
    chk("R7 alarm line rose", 32'(irq_alarm), 1);
    rd('h10, d); chk("R7 time at alarm", d, 103);
    rd('h20, d); chk("R10 status sets while masked", d, 3);
    chk("R10 masked sec line low", 32'(irq_sec), 0);
    wr('h20, 32'h2);
    rd('h20, d); chk("R8 clear alarm only", d, 1);
    chk("R10 alarm line dropped", 32'(irq_alarm), 0);
    wr('h20, 32'h0);
    rd('h20, d); chk("R8 zero write keeps bit", d, 1);

    wr('h28, 32'h1); rd('h24, d); chk("R9 both enabled", d, 3);
    chk("R10 sec line follows enable", 32'(irq_sec), 1);
    wr('h2C, 32'h2); rd('h24, d); chk("R9 disable alarm", d, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule